// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block turns an asynchronous serial input into parallel words. All framing parameters are runtime inputs: the bit duration in system clocks, the word length (5 to 8 bits), an optional parity bit of even or odd type, the stop length (1, 1.5 or 2 bits), the resting polarity of the line, and two sampling offsets given in sixteenths of a bit. A higher-level block supplies these fields and collects the results. Storage of received words, bus access and the derivation of the bit duration from a baud rate are not part of it.

The line passes through a two-stage synchronizer. The receiver then times each bit with a single cycle counter and takes every bit at a programmable phase. Each accepted frame produces one registered strobe together with the word, a parity flag and a framing flag. The configuration is read live and must not change while a frame is in progress.

Top module: `serial_rx_core`

## Requirements
- R1: During and directly after the synchronous reset, `rx_valid`, `rx_data`, `rx_par_err` and `rx_frm_err` are all 0.
- R2: Let P be `cfg_period` (32 or more), ph = floor(P/16), D = `cfg_data_phase`·ph, W the word length and N = 1 + W + `cfg_par_en`. Let c be the first rising edge at which `rx_line` shows the non-idle level while the receiver is idle and enabled. Then `rx_valid` is high for exactly the one cycle that follows edge c+3+N·P+D. `rx_data` and both flags hold their values until the next strobe.
- R3: Data bits arrive least significant first. A bit reads as 1 when the line is at the idle level at that bit's data-sample point. Bit k is sampled at offset (k+1)·P+D cycles from the frame start.
- R4: Word-length codes on `cfg_width`: 101 gives 5 bits, 110 gives 6, 111 gives 7, and any other code gives 8. Bits of `rx_data` above the word length are 0.
- R5: At offset S = `cfg_start_phase`·ph, the line is checked again. If it has returned to the idle level, the frame is dropped with no strobe, and the receiver looks for a new start on the next cycle.
- R6: When `cfg_par_en` is 1, one parity bit follows the data. With `cfg_par_odd` = 0, `rx_par_err` is set when data plus parity hold an odd count of ones. With `cfg_par_odd` = 1, it is set when the count is even. With parity off, `rx_par_err` is 0.
- R7: `rx_frm_err` is set when the line is not at the idle level at the first stop sample (offset N·P+D).
- R8: Stop-length code on `cfg_stop`: 00 gives P, 01 gives P+floor(P/2), and 10 or 11 give 2P cycles. No new start is recognised until that many cycles after the stop bit begins.
- R9: While `rx_enable` is 0, the receiver stays idle, any frame in progress is dropped, and no strobe is produced.
- R10: With `cfg_idle_high` = 0, the line rests low and every level reads inverted: a start bit is high, and a data bit reads 1 when the line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Asynchronous serial input |
| rx_enable | input | 1 | Receiver enable |
| cfg_idle_high | input | 1 | 1: line rests high, 0: line rests low |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 0 even parity, 1 odd parity |
| cfg_stop | input | 2 | Stop-length code |
| cfg_width | input | 3 | Word-length code |
| cfg_start_phase | input | PHASE_W | Start re-check point in sixteenths of a bit |
| cfg_data_phase | input | PHASE_W | Bit sample point in sixteenths of a bit |
| cfg_period | input | PERIOD_W | System clocks per bit |
| rx_valid | output | 1 | One-cycle word strobe |
| rx_data | output | 8 | Received word, zero-filled |
| rx_par_err | output | 1 | Parity error for the word |
| rx_frm_err | output | 1 | Framing error for the word |

## Verification
The hardest case to reach is a start edge that arrives while the receiver is still inside a long stop interval. The receiver then has to ignore that edge and lock onto whatever level it finds once the interval ends, which often means it frames a word out of the middle of the next frame. The stimulus reaches this case by sending frames with one stop bit while the receiver expects two, and also by sending a deliberately broken stop bit, whose trailing low level turns into a start that is rejected. In both cases the bench model replays the recorded line history to predict the exact strobe cycle and the word. Short pulses below the re-check point, and removal of the enable in mid-frame, cover the drop paths.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int unsigned WORD_MAX = 8;
  localparam int unsigned IDX_W    = 4;

  typedef enum logic {RX_IDLE, RX_FRAME} rx_state_e;

  function automatic logic [IDX_W-1:0] word_len(input logic [2:0] code);
    case (code)
      3'b101:  return IDX_W'(5);
      3'b110:  return IDX_W'(6);
      3'b111:  return IDX_W'(7);
      default: return IDX_W'(WORD_MAX);
    endcase
  endfunction
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/srx_timing.sv
module srx_timing #(
  parameter int unsigned PERIOD_W = 16,
  parameter int unsigned PHASE_W  = 4,
  localparam int unsigned CNT_W   = PERIOD_W + 1
) (
  input  logic [PERIOD_W-1:0] period,
  input  logic [PHASE_W-1:0]  start_phase,
  input  logic [PHASE_W-1:0]  data_phase,
  input  logic [1:0]          stop_code,
  output logic [CNT_W-1:0]    start_at,
  output logic [CNT_W-1:0]    data_at,
  output logic [CNT_W-1:0]    bit_last,
  output logic [CNT_W-1:0]    stop_last
);
  logic [CNT_W-1:0] per_x, slice, stop_len;

  assign per_x    = CNT_W'(period);
  assign slice    = CNT_W'(period >> PHASE_W);
  assign start_at = CNT_W'(start_phase) * slice;
  assign data_at  = CNT_W'(data_phase) * slice;
  assign bit_last = per_x - CNT_W'(1);

  always_comb begin
    case (stop_code)
      2'b00:   stop_len = per_x;
      2'b01:   stop_len = per_x + (per_x >> 1);
      default: stop_len = per_x << 1;
    endcase
  end

  assign stop_last = stop_len - CNT_W'(1);
endmodule

// File: rtl/srx_frame.sv
module srx_frame import srx_pkg::*; #(
  parameter int unsigned CNT_W = 17
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic                bit_mark,
  input  logic [2:0]          width_code,
  input  logic                par_en,
  input  logic                par_odd,
  input  logic [CNT_W-1:0]    start_at,
  input  logic [CNT_W-1:0]    data_at,
  input  logic [CNT_W-1:0]    bit_last,
  input  logic [CNT_W-1:0]    stop_last,
  output logic                valid,
  output logic [WORD_MAX-1:0] data,
  output logic                par_err,
  output logic                frm_err
);
  rx_state_e           state;
  logic [CNT_W-1:0]    cnt;
  logic [IDX_W-1:0]    idx;
  logic [WORD_MAX-1:0] shreg;
  logic                pbit;
  logic [IDX_W-1:0]    nbits, stop_idx;
  logic                at_sample;

  assign nbits     = word_len(width_code);
  assign stop_idx  = IDX_W'(1) + nbits + IDX_W'(par_en);
  assign at_sample = (cnt == data_at);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_IDLE;
      cnt     <= '0;
      idx     <= '0;
      shreg   <= '0;
      pbit    <= 1'b0;
      valid   <= 1'b0;
      data    <= '0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (!enable) begin
        state <= RX_IDLE;
      end else if (state == RX_IDLE) begin
        if (!bit_mark) begin
          state <= RX_FRAME;
          cnt   <= '0;
          idx   <= '0;
          shreg <= '0;
          pbit  <= 1'b0;
        end
      end else if (idx == '0 && cnt == start_at && bit_mark) begin
        state <= RX_IDLE;
      end else if (idx == stop_idx) begin
        if (at_sample) begin
          valid   <= 1'b1;
          data    <= shreg;
          par_err <= par_en & (^shreg ^ pbit ^ par_odd);
          frm_err <= !bit_mark;
        end
        if (cnt == stop_last) state <= RX_IDLE;
        else                  cnt   <= cnt + CNT_W'(1);
      end else begin
        for (int b = 0; b < WORD_MAX; b++) begin
          if (at_sample && idx == IDX_W'(b + 1) && idx <= nbits) shreg[b] <= bit_mark;
        end
        if (at_sample && par_en && idx == nbits + IDX_W'(1)) pbit <= bit_mark;
        if (cnt == bit_last) begin
          cnt <= '0;
          idx <= idx + IDX_W'(1);
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  AST_ONE_CYCLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid) else $error("strobe longer than one cycle"); // R2
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !valid) else $error("strobe while disabled"); // R9
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
    valid |-> ((data >> nbits) == '0)) else $error("bits above word length set"); // R4
  AST_BIT_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (state == RX_FRAME && idx != stop_idx) |-> (cnt <= bit_last)) else $error("bit counter overran"); // R2
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state == RX_FRAME) |-> (idx <= stop_idx)) else $error("bit index past stop"); // R8
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core import srx_pkg::*; #(
  parameter int unsigned PERIOD_W    = 16,
  parameter int unsigned PHASE_W     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_line,
  input  logic                rx_enable,
  input  logic                cfg_idle_high,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic [1:0]          cfg_stop,
  input  logic [2:0]          cfg_width,
  input  logic [PHASE_W-1:0]  cfg_start_phase,
  input  logic [PHASE_W-1:0]  cfg_data_phase,
  input  logic [PERIOD_W-1:0] cfg_period,
  output logic                rx_valid,
  output logic [WORD_MAX-1:0] rx_data,
  output logic                rx_par_err,
  output logic                rx_frm_err
);
  localparam int unsigned CNT_W = PERIOD_W + 1;

  logic             line_s, mark;
  logic [CNT_W-1:0] start_at, data_at, bit_last, stop_last;

  srx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(rx_line), .q(line_s)
  );

  assign mark = (line_s == cfg_idle_high);

  srx_timing #(.PERIOD_W(PERIOD_W), .PHASE_W(PHASE_W)) u_timing (
    .period(cfg_period), .start_phase(cfg_start_phase), .data_phase(cfg_data_phase),
    .stop_code(cfg_stop), .start_at(start_at), .data_at(data_at),
    .bit_last(bit_last), .stop_last(stop_last)
  );

  srx_frame #(.CNT_W(CNT_W)) u_frame (
    .clk(clk), .rst(rst), .enable(rx_enable), .bit_mark(mark),
    .width_code(cfg_width), .par_en(cfg_par_en), .par_odd(cfg_par_odd),
    .start_at(start_at), .data_at(data_at), .bit_last(bit_last), .stop_last(stop_last),
    .valid(rx_valid), .data(rx_data), .par_err(rx_par_err), .frm_err(rx_frm_err)
  );
endmodule

// File: tb/serial_rx_core_bench.sv
module serial_rx_core_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, rx_line = 1'b1, rx_enable = 1'b0;
  logic cfg_idle_high = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic [1:0] cfg_stop = 2'b00;
  logic [2:0] cfg_width = 3'b000;
  logic [3:0] cfg_start_phase = 4'd6, cfg_data_phase = 4'd4;
  logic [15:0] cfg_period = 16'd32;
  logic rx_valid, rx_par_err, rx_frm_err;
  logic [7:0] rx_data;

  serial_rx_core u_serial_rx_core (
    .clk(clk), .rst(rst), .rx_line(rx_line), .rx_enable(rx_enable),
    .cfg_idle_high(cfg_idle_high), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop(cfg_stop), .cfg_width(cfg_width), .cfg_start_phase(cfg_start_phase),
    .cfg_data_phase(cfg_data_phase), .cfg_period(cfg_period),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err)
  );

  int n_chk = 0, n_bad = 0, strobes = 0;
  string cur_req = "R2";
  bit done = 0;

  function automatic int wbits(input logic [2:0] c);
    if (c == 3'b101) return 5;
    if (c == 3'b110) return 6;
    if (c == 3'b111) return 7;
    return 8;
  endfunction

  // Behavioural reference: replays the line as the receiver sees it after two sync stages.
  logic d1 = 1'b1, d2 = 1'b1, lh, mk, busy = 1'b0, mp;
  logic [7:0] md;
  logic exp_v = 1'b0, exp_p = 1'b0, exp_f = 1'b0;
  logic [7:0] exp_d = '0;
  int k, p, ph, s, d, w, n, l, j;

  always @(posedge clk) begin
    exp_v = 1'b0;
    lh = d2; d2 = d1; d1 = rx_line;
    mk = (lh == cfg_idle_high);
    if (rst) begin
      busy = 1'b0; d1 = 1'b1; d2 = 1'b1;
    end else if (!rx_enable) begin
      busy = 1'b0;
    end else if (!busy) begin
      if (!mk) begin busy = 1'b1; k = 0; md = '0; mp = 1'b0; end
    end else begin
      p = cfg_period; ph = p / 16; s = cfg_start_phase * ph; d = cfg_data_phase * ph;
      w = wbits(cfg_width); n = 1 + w + cfg_par_en;
      l = (cfg_stop == 2'b00) ? p : (cfg_stop == 2'b01) ? p + p / 2 : 2 * p;
      if (k == s && mk) begin
        busy = 1'b0;
      end else begin
        j = k / p;
        if (k % p == d && j >= 1 && j <= w) md[j-1] = mk;
        if (cfg_par_en && k % p == d && j == w + 1) mp = mk;
        if (k == n * p + d) begin
          exp_v = 1'b1; exp_d = md;
          exp_p = cfg_par_en & (^md ^ mp ^ cfg_par_odd);
          exp_f = !mk;
        end
        if (k == n * p + l - 1) busy = 1'b0;
        k++;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && (exp_v || rx_valid)) begin
      n_chk++;
      if (rx_valid) strobes++;
      if (rx_valid !== exp_v || (exp_v && (rx_data !== exp_d || rx_par_err !== exp_p || rx_frm_err !== exp_f))) begin
        n_bad++;
        $display("FAIL %s strobe: got v=%b d=%h p=%b f=%b expected v=%b d=%h p=%b f=%b",
                 cur_req, rx_valid, rx_data, rx_par_err, rx_frm_err, exp_v, exp_d, exp_p, exp_f);
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic send(input logic [7:0] wd, input bit bad_par, input bit bad_stop, input int stop_cyc, input int gap);
    int pp, nb;
    logic idl, pb;
    logic [7:0] msk;
    pp = cfg_period; nb = wbits(cfg_width); idl = cfg_idle_high;
    msk = 8'((9'd1 << nb) - 9'd1);
    rx_line = !idl; repeat (pp) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rx_line = wd[i] ? idl : !idl; repeat (pp) @(negedge clk);
    end
    if (cfg_par_en) begin
      pb = (^(wd & msk)) ^ cfg_par_odd ^ bad_par;
      rx_line = pb ? idl : !idl; repeat (pp) @(negedge clk);
    end
    if (bad_stop) begin rx_line = !idl; repeat (pp) @(negedge clk); end
    rx_line = idl;
    repeat (stop_cyc + gap) @(negedge clk);
  endtask

  task automatic frm(input logic [7:0] wd);
    send(wd, 1'b0, 1'b0, 2 * cfg_period, 3 * cfg_period + 40);
  endtask

  task automatic begin_phase(input string req);
    cur_req = req; strobes = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R1", "valid after reset", rx_valid, 0);
    chk("R1", "data after reset", rx_data, 0);
    chk("R1", "parity flag after reset", rx_par_err, 0);
    chk("R1", "framing flag after reset", rx_frm_err, 0);
    rst = 1'b0; rx_enable = 1'b1;
    repeat (4) @(negedge clk);

    begin_phase("R3");
    frm(8'h55); frm(8'hA3); frm(8'h00); frm(8'hFF); frm(8'h01);
    chk("R3", "word count", strobes, 5);
    chk("R3", "last word", rx_data, 8'h01);

    begin_phase("R2");
    cfg_period = 16'd48; cfg_start_phase = 4'd3; cfg_data_phase = 4'd12;
    frm(8'h96); frm(8'h3C);
    cfg_period = 16'd37; cfg_start_phase = 4'd7; cfg_data_phase = 4'd9;
    frm(8'hC5);
    chk("R2", "word count", strobes, 3);
    chk("R2", "held data", rx_data, 8'hC5);
    cfg_period = 16'd32; cfg_start_phase = 4'd6; cfg_data_phase = 4'd8;

    begin_phase("R4");
    cfg_width = 3'b101; frm(8'hFF);
    chk("R4", "5-bit zero fill", rx_data, 8'h1F);
    cfg_width = 3'b110; frm(8'hEA);
    cfg_width = 3'b111; frm(8'hFF);
    chk("R4", "7-bit zero fill", rx_data, 8'h7F);
    cfg_width = 3'b010; frm(8'hB7);
    chk("R4", "other code is 8 bits", rx_data, 8'hB7);
    chk("R4", "word count", strobes, 4);
    cfg_width = 3'b000;

    begin_phase("R6");
    cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    frm(8'h35);
    chk("R6", "even parity good", rx_par_err, 0);
    send(8'h35, 1'b1, 1'b0, 64, 140);
    chk("R6", "even parity bad", rx_par_err, 1);
    cfg_par_odd = 1'b1;
    frm(8'h70);
    chk("R6", "odd parity good", rx_par_err, 0);
    send(8'h70, 1'b1, 1'b0, 64, 140);
    chk("R6", "odd parity bad", rx_par_err, 1);
    cfg_par_en = 1'b0; cfg_par_odd = 1'b0;

    begin_phase("R7");
    send(8'h5A, 1'b0, 1'b1, 64, 140);
    chk("R7", "framing flag set", rx_frm_err, 1);
    chk("R7", "word count", strobes, 1);
    frm(8'h5A);
    chk("R7", "framing flag clear", rx_frm_err, 0);

    begin_phase("R5");
    rx_line = 1'b0; repeat (4) @(negedge clk);
    rx_line = 1'b1; repeat (100) @(negedge clk);
    rx_line = 1'b0; repeat (11) @(negedge clk);
    rx_line = 1'b1; repeat (100) @(negedge clk);
    chk("R5", "short pulses give no word", strobes, 0);
    frm(8'h81);
    chk("R5", "receiver ready after drop", rx_data, 8'h81);

    begin_phase("R8");
    cfg_stop = 2'b10;
    send(8'h42, 1'b0, 1'b0, 64, 0); frm(8'h24);
    cfg_stop = 2'b01;
    send(8'h99, 1'b0, 1'b0, 48, 0); frm(8'h66);
    chk("R8", "full stop spacing keeps both words", strobes, 4);
    cfg_stop = 2'b10;
    send(8'h0F, 1'b0, 1'b0, 32, 0); send(8'h00, 1'b0, 1'b0, 64, 140);
    send(8'h3E, 1'b0, 1'b0, 32, 0); send(8'hF0, 1'b0, 1'b0, 64, 140);
    cfg_stop = 2'b00;

    begin_phase("R9");
    fork
      frm(8'hA5);
      begin repeat (160) @(negedge clk); rx_enable = 1'b0; end
    join
    frm(8'h5A);
    chk("R9", "no word while disabled", strobes, 0);
    rx_enable = 1'b1;
    frm(8'hC3);
    chk("R9", "word after re-enable", rx_data, 8'hC3);

    begin_phase("R10");
    rx_enable = 1'b0; cfg_idle_high = 1'b0; rx_line = 1'b0;
    repeat (6) @(negedge clk);
    rx_enable = 1'b1;
    repeat (4) @(negedge clk);
    frm(8'h96); frm(8'h3C);
    chk("R10", "word count low idle", strobes, 2);
    chk("R10", "inverted data", rx_data, 8'h3C);

    done = 1;
    summary();
    $finish;
  end
endmodule